// File: doc/BRIEF.md
# Clocked Synchronous Serial Transceiver

This block is a full-duplex synchronous serial port. Each frame moves eight bits out on a transmit data pin and eight bits in on a receive data pin, least significant bit first, with both directions timed by one serial clock. The clock either comes from an internal divider, in which case the block drives the clock pin, or from an external master through the clock input pin.

Software works through a small register-style host port. It has a control register, a divider register, a transmit buffer and a receive buffer, plus a status word with three flags: transmit buffer empty, receive full and overrun. The transmitter is the only thing that starts a frame. A frame is armed only when transmit is enabled and the transmit buffer holds a byte. For that reason a device that only receives still writes a dummy byte for every frame, and those dummy bits appear on the data output. An optional clear-to-send input gates the start of a frame. In external-clock mode, an optional ready output goes low while the port is armed and waiting, and it returns high on the first clock edge of the frame.

When a frame completes and the receive buffer is free, the received byte is stored and a one-cycle receive interrupt pulse is raised. When a frame completes while the buffer is still full, the overrun flag is set and no interrupt is raised.

Top module: `sync_serial_xcvr`

## Requirements
- R1: Transmit bits go out on `txd_o` least significant bit first, one bit per frame clock period. Each bit changes on the drive edge: the falling edge when polarity (control bit 3) is 0, the rising edge when it is 1. The bit is stable at the following sample edge. `txd_o` is 1 after reset.
- R2: Received bits are sampled from `rxd_i` on the sample edge: the rising edge at polarity 0, the falling edge at polarity 1. The first bit sampled lands in bit 0 of the byte read at address 3.
- R3: No serial clock edge is produced and no frame starts unless transmit enable (control bit 0) is 1 and the transmit buffer holds a byte. The status bit 0, transmit empty, is 1 after reset, goes to 0 on a write to address 2, and returns to 1 when a frame is armed.
- R4: With clear-to-send gating enabled (control bit 4), a frame does not start while `cts_ni` is high. It starts once `cts_ni` is low.
- R5: In internal-clock mode (control bit 2 = 0), `sclk_o` has a period of 2×(N+1) system clocks, where N is the divider at address 1. Between frames it idles high at polarity 0 and low at polarity 1. `sclk_oe_o` is 1 in internal mode and 0 in external mode.
- R6: A completed frame with receive enable (control bit 1) set and the buffer free sets receive full (status bit 1) and raises `rx_irq_o` for exactly one cycle. A read of address 3 with `rd_en_i` high clears receive full.
- R7: A frame that completes while receive full is 1 sets overrun (status bit 2) and raises no interrupt. Overrun clears when receive enable is 0.
- R8: With receive enable at 0 a frame still runs, but receive full stays 0 and no interrupt is raised.
- R9: In external-clock mode (control bit 2 = 1), the frame is shifted on edges of `sclk_i` after a two-flop synchronizer. A frame is armed only while `sclk_i` rests at its idle level.
- R10: `rts_no` is low only in external-clock mode with the ready function (control bit 5) and receive enable set, while a frame is armed and before its first drive edge. It is high at all other times, including always in internal-clock mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Host write strobe |
| wr_addr_i | input | 2 | Write address: 0 control, 1 divider, 2 transmit buffer |
| wr_data_i | input | DATA_W | Host write data |
| rd_en_i | input | 1 | Host read strobe; at address 3 it clears receive full |
| rd_addr_i | input | 2 | Read address: 0 control, 1 divider, 2 status, 3 receive buffer |
| rd_data_o | output | DATA_W | Host read data (combinational) |
| sclk_i | input | 1 | External serial clock |
| sclk_o | output | 1 | Internally generated serial clock |
| sclk_oe_o | output | 1 | Clock pin output enable |
| txd_o | output | 1 | Serial transmit data |
| rxd_i | input | 1 | Serial receive data |
| cts_ni | input | 1 | Clear to send, active low |
| rts_no | output | 1 | Ready to receive, active low |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
Assertions watch four things on every cycle:
- the interrupt never lasts more than one cycle;
- an overrun completion never raises it;
- a frame is never armed without transmit enable and a buffered byte;
- no sample edge arrives before a drive edge, and the ready output is high after any drive edge.

Bit order, clock period, idle levels, clear-to-send holding, the overrun clear rule and the external-clock handshake are only visible from scenarios. The bench plays the remote device in those scenarios, capturing `txd_o` and driving `rxd_i` on the proper edges.

// File: rtl/ssx_pkg.sv
package ssx_pkg;
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_DIV  = 2'd1;
  localparam logic [1:0] A_TXD  = 2'd2;  // write
  localparam logic [1:0] A_STAT = 2'd2;  // read
  localparam logic [1:0] A_RXD  = 2'd3;

  typedef struct packed {
    logic rts_en;
    logic cts_en;
    logic pol;
    logic ext;
    logic rx_en;
    logic tx_en;
  } ctrl_t;
endpackage

// File: rtl/ssx_sync.sv
module ssx_sync #(
  parameter int          W       = 1,
  parameter int          STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) st_q[i] <= {W{RST_VAL}};
    end else begin
      st_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ssx_clkgen.sv
module ssx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ext_i,
  input  logic             pol_i,
  input  logic             busy_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic             div_wr_i,
  input  logic             sclk_i,
  output logic             sclk_o,
  output logic             drive_evt_o,
  output logic             sample_evt_o,
  output logic             clk_idle_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             sclk_q;
  logic             ext_s, ext_prev_q;
  logic             tick, at_idle, ext_rise, ext_fall;

  ssx_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_sclk_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sclk_i), .q_o(ext_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      sclk_q     <= 1'b1;
      ext_prev_q <= 1'b1;
    end else begin
      ext_prev_q <= ext_s;
      if (!busy_i) begin
        cnt_q  <= '0;
        sclk_q <= ~pol_i;
      end else if (ext_i || div_wr_i) begin
        cnt_q <= '0;                       // divider reload
      end else if (cnt_q == div_i) begin
        cnt_q  <= '0;
        sclk_q <= ~sclk_q;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign tick     = busy_i && !ext_i && !div_wr_i && (cnt_q == div_i);
  assign at_idle  = (sclk_q == ~pol_i);
  assign ext_rise = ext_s & ~ext_prev_q;
  assign ext_fall = ~ext_s & ext_prev_q;

  always_comb begin
    if (ext_i) begin
      drive_evt_o  = busy_i && (pol_i ? ext_rise : ext_fall);
      sample_evt_o = busy_i && (pol_i ? ext_fall : ext_rise);
    end else begin
      drive_evt_o  = tick && at_idle;
      sample_evt_o = tick && !at_idle;
    end
  end

  assign clk_idle_o = !ext_i || (ext_s == ~pol_i);
  assign sclk_o     = sclk_q;
endmodule

// File: rtl/ssx_shifter.sv
module ssx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              drive_evt_i,
  input  logic              sample_evt_i,
  input  logic              rxd_i,
  output logic              busy_o,
  output logic              active_o,
  output logic              txd_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_frame_o
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [DATA_W-1:0] tx_sh_q, rx_sh_q;
  logic [CNT_W-1:0]  bcnt_q;
  logic              busy_q, active_q, txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_sh_q  <= '0;
      rx_sh_q  <= '0;
      bcnt_q   <= '0;
      busy_q   <= 1'b0;
      active_q <= 1'b0;
      txd_q    <= 1'b1;
    end else if (start_i) begin
      tx_sh_q  <= tx_data_i;
      bcnt_q   <= '0;
      busy_q   <= 1'b1;
      active_q <= 1'b0;
    end else begin
      if (drive_evt_i) begin
        txd_q    <= tx_sh_q[0];
        tx_sh_q  <= tx_sh_q >> 1;
        active_q <= 1'b1;
      end
      if (sample_evt_i) begin
        rx_sh_q <= {rxd_i, rx_sh_q[DATA_W-1:1]};
        if (bcnt_q == LAST) begin
          bcnt_q   <= '0;
          busy_q   <= 1'b0;
          active_q <= 1'b0;
        end else begin
          bcnt_q <= bcnt_q + 1'b1;
        end
      end
    end
  end

  assign done_o     = sample_evt_i && (bcnt_q == LAST);
  assign rx_frame_o = {rxd_i, rx_sh_q[DATA_W-1:1]};
  assign busy_o     = busy_q;
  assign active_o   = active_q;
  assign txd_o      = txd_q;

  a_r1_sample_after_drive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sample_evt_i |-> active_q)
    else $error("R1: sample edge before any drive edge");
endmodule

// File: rtl/ssx_rxbuf.sv
module ssx_rxbuf #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W-1:0] frame_i,
  input  logic              rx_en_i,
  input  logic              rd_clr_i,
  output logic [DATA_W-1:0] data_o,
  output logic              full_o,
  output logic              ovr_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] data_q;
  logic              full_q, ovr_q, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (done_i && rx_en_i) begin
        data_q <= frame_i;             // contents undefined on overrun
        if (full_q) ovr_q <= 1'b1;
        else begin
          full_q <= 1'b1;
          irq_q  <= 1'b1;
        end
      end else if (rd_clr_i) begin
        full_q <= 1'b0;
      end
      if (!rx_en_i) ovr_q <= 1'b0;
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign irq_o  = irq_q;

  a_r6_irq_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_q |=> !irq_q)
    else $error("R6: interrupt longer than one cycle");

  a_r7_ovr_no_irq: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && rx_en_i && full_q) |=> (!irq_q && ovr_q))
    else $error("R7: overrun raised interrupt or missed flag");
endmodule

// File: rtl/sync_serial_xcvr.sv
module sync_serial_xcvr
  import ssx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DIV_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  input  logic [1:0]        rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              sclk_i,
  output logic              sclk_o,
  output logic              sclk_oe_o,
  output logic              txd_o,
  input  logic              rxd_i,
  input  logic              cts_ni,
  output logic              rts_no,
  output logic              rx_irq_o
);
  localparam int CTRL_W = $bits(ctrl_t);

  ctrl_t             ctrl_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] tx_hold_q, rx_data;
  logic              tx_empty_q;
  logic              cts_s, cts_ok, clk_idle, start;
  logic              busy, active, drive_evt, sample_evt, done;
  logic              rx_full, rx_ovr, rd_clr, div_wr;
  logic [DATA_W-1:0] rx_frame;

  assign div_wr = wr_en_i && (wr_addr_i == A_DIV);
  assign rd_clr = rd_en_i && (rd_addr_i == A_RXD);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q     <= '0;
      div_q      <= '0;
      tx_hold_q  <= '0;
      tx_empty_q <= 1'b1;
    end else begin
      if (wr_en_i && wr_addr_i == A_CTRL) ctrl_q <= ctrl_t'(wr_data_i[CTRL_W-1:0]);
      if (div_wr) div_q <= wr_data_i[DIV_W-1:0];
      if (wr_en_i && wr_addr_i == A_TXD) begin
        tx_hold_q  <= wr_data_i;
        tx_empty_q <= 1'b0;
      end else if (start) begin
        tx_empty_q <= 1'b1;
      end
    end
  end

  ssx_sync #(.W(1), .STAGES(2), .RST_VAL(1'b1)) u_cts_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(cts_ni), .q_o(cts_s)
  );

  assign cts_ok = !ctrl_q.cts_en || !cts_s;
  assign start  = !busy && ctrl_q.tx_en && !tx_empty_q && cts_ok && clk_idle;

  ssx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ctrl_q.ext), .pol_i(ctrl_q.pol),
    .busy_i(busy), .div_i(div_q), .div_wr_i(div_wr), .sclk_i(sclk_i),
    .sclk_o(sclk_o), .drive_evt_o(drive_evt), .sample_evt_o(sample_evt),
    .clk_idle_o(clk_idle)
  );

  ssx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start), .tx_data_i(tx_hold_q),
    .drive_evt_i(drive_evt), .sample_evt_i(sample_evt), .rxd_i(rxd_i),
    .busy_o(busy), .active_o(active), .txd_o(txd_o), .done_o(done),
    .rx_frame_o(rx_frame)
  );

  ssx_rxbuf #(.DATA_W(DATA_W)) u_rxbuf (
    .clk_i(clk_i), .rst_ni(rst_ni), .done_i(done), .frame_i(rx_frame),
    .rx_en_i(ctrl_q.rx_en), .rd_clr_i(rd_clr), .data_o(rx_data),
    .full_o(rx_full), .ovr_o(rx_ovr), .irq_o(rx_irq_o)
  );

  always_comb begin
    unique case (rd_addr_i)
      A_CTRL:  rd_data_o = DATA_W'(ctrl_q);
      A_DIV:   rd_data_o = DATA_W'(div_q);
      A_STAT:  rd_data_o = DATA_W'({rx_ovr, rx_full, tx_empty_q});
      default: rd_data_o = rx_data;
    endcase
  end

  assign sclk_oe_o = !ctrl_q.ext;
  // ready: armed in external mode, first edge not yet seen
  assign rts_no = !(ctrl_q.ext && ctrl_q.rts_en && ctrl_q.rx_en && busy && !active);

  a_r3_arm_needs_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(ctrl_q.tx_en && !tx_empty_q))
    else $error("R3: frame armed without enable or data");

  a_r10_rts_high_after_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drive_evt |=> rts_no)
    else $error("R10: ready low after frame began");
endmodule

// File: tb/sim_sync_serial_xcvr.sv
`timescale 1ns/1ps
module sim_sync_serial_xcvr;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i, rd_en_i;
  logic [1:0] wr_addr_i, rd_addr_i;
  logic [7:0] wr_data_i, rd_data_o;
  logic       sclk_i, sclk_o, sclk_oe_o, txd_o, rxd_i, cts_ni, rts_no, rx_irq_o;

  int checks = 0, errors = 0, irq_cnt = 0, tog_cnt = 0;
  bit finished = 0;

  always #2.5 clk_i = ~clk_i;

  sync_serial_xcvr u0 (.*);

  always @(negedge clk_i) if (rx_irq_o === 1'b1) irq_cnt++;
  always @(sclk_o) tog_cnt++;

  // pol[24] div[23:16] tx[15:8] rx[7:0]
  localparam logic [24:0] VEC [4] = '{
    {1'b0, 8'd0, 8'hA5, 8'h3C},
    {1'b1, 8'd2, 8'h81, 8'h7E},
    {1'b0, 8'd5, 8'h01, 8'h80},
    {1'b1, 8'd1, 8'hFF, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic host_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic host_rd(input logic [1:0] a, input logic clr, output logic [7:0] d);
    @(negedge clk_i);
    rd_addr_i = a; rd_en_i = clr;
    #1 d = rd_data_o;
    @(negedge clk_i);
    rd_en_i = 1'b0;
  endtask

  task automatic remote(input logic pol, input logic [7:0] rx, output logic [7:0] cap);
    for (int i = 0; i < 8; i++) begin
      if (pol) @(posedge sclk_o); else @(negedge sclk_o);
      rxd_i = rx[i];
      if (pol) @(negedge sclk_o); else @(posedge sclk_o);
      cap[i] = txd_o;
    end
  endtask

  task automatic run_int(input logic pol, input logic [7:0] dv, input logic [7:0] tx,
                         input logic [7:0] rx, output logic [7:0] cap);
    host_wr(2'd0, 8'h03 | (8'(pol) << 3));
    host_wr(2'd1, dv);
    fork
      remote(pol, rx, cap);
      host_wr(2'd2, tx);
    join
    repeat (4) @(negedge clk_i);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, cap;
    int i0, t0, rts_low;
    logic rts_mid;
    realtime r0, r1;
    rst_ni = 1'b0; wr_en_i = 0; rd_en_i = 0; wr_addr_i = 0; rd_addr_i = 0;
    wr_data_i = 0; sclk_i = 1'b1; rxd_i = 1'b1; cts_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // reset state
    host_rd(2'd2, 1'b0, d);
    chk("R3 reset status", d, 8'h01);
    chk("R1 reset txd", txd_o, 1'b1);
    chk("R10 reset rts", rts_no, 1'b1);
    chk("R5 reset sclk idle", {sclk_o, sclk_oe_o}, 2'b11);
    chk("R6 reset irq", rx_irq_o, 1'b0);

    // vector table: R1 R2 R6
    foreach (VEC[k]) begin
      i0 = irq_cnt;
      run_int(VEC[k][24], VEC[k][23:16], VEC[k][15:8], VEC[k][7:0], cap);
      chk("R1 tx bits lsb first", cap, VEC[k][15:8]);
      chk("R6 one irq per frame", irq_cnt - i0, 1);
      host_rd(2'd2, 1'b0, d);
      chk("R6 rx full set", d[1], 1'b1);
      host_rd(2'd3, 1'b1, d);
      chk("R2 rx data", d, VEC[k][7:0]);
      host_rd(2'd2, 1'b0, d);
      chk("R6 read clears full", d[1], 1'b0);
    end

    // R7 overrun
    i0 = irq_cnt;
    run_int(1'b0, 8'd0, 8'h11, 8'h22, cap);
    run_int(1'b0, 8'd0, 8'h33, 8'h44, cap);
    host_rd(2'd2, 1'b0, d);
    chk("R7 overrun flag", d[2:1], 2'b11);
    chk("R7 no irq on overrun", irq_cnt - i0, 1);
    host_rd(2'd3, 1'b1, d);
    host_rd(2'd2, 1'b0, d);
    chk("R7 overrun kept while rx enabled", d[2:1], 2'b10);
    host_wr(2'd0, 8'h01);
    host_rd(2'd2, 1'b0, d);
    chk("R7 overrun cleared by rx disable", d[2], 1'b0);

    // R8 rx disabled
    i0 = irq_cnt; t0 = tog_cnt;
    host_wr(2'd2, 8'h5A);
    repeat (40) @(negedge clk_i);
    host_rd(2'd2, 1'b0, d);
    chk("R8 no rx full when disabled", d[1:0], 2'b01);
    chk("R8 no irq when disabled", irq_cnt - i0, 0);
    chk("R8 frame still ran", tog_cnt - t0, 16);

    // R3 gating by tx enable and buffered data
    host_wr(2'd0, 8'h03);
    t0 = tog_cnt;
    repeat (30) @(negedge clk_i);
    chk("R3 no clock when buffer empty", tog_cnt - t0, 0);
    host_wr(2'd0, 8'h02);
    host_wr(2'd2, 8'hC3);
    t0 = tog_cnt;
    repeat (40) @(negedge clk_i);
    host_rd(2'd2, 1'b0, d);
    chk("R3 no clock without tx enable", tog_cnt - t0, 0);
    chk("R3 data held", d[0], 1'b0);
    host_wr(2'd0, 8'h03);
    repeat (40) @(negedge clk_i);
    host_rd(2'd2, 1'b0, d);
    chk("R3 frame after enable", tog_cnt - t0, 16);
    chk("R3 buffer emptied", d[0], 1'b1);
    host_rd(2'd3, 1'b1, d);

    // R4 CTS gating
    host_wr(2'd0, 8'h13);
    cts_ni = 1'b1;
    host_wr(2'd2, 8'h3C);
    t0 = tog_cnt;
    repeat (40) @(negedge clk_i);
    host_rd(2'd2, 1'b0, d);
    chk("R4 held by cts high", tog_cnt - t0, 0);
    chk("R4 data still buffered", d[0], 1'b0);
    cts_ni = 1'b0;
    repeat (40) @(negedge clk_i);
    chk("R4 frame after cts low", tog_cnt - t0, 16);
    cts_ni = 1'b1;
    host_rd(2'd3, 1'b1, d);

    // R5 period and idle levels
    host_wr(2'd0, 8'h0B);
    host_wr(2'd1, 8'd3);
    chk("R5 idle low at pol 1", sclk_o, 1'b0);
    fork
      begin @(posedge sclk_o); r0 = $realtime; @(posedge sclk_o); r1 = $realtime; end
      host_wr(2'd2, 8'h00);
    join
    chk("R5 period 2*(N+1)", int'((r1 - r0) / 5.0), 8);
    repeat (80) @(negedge clk_i);
    chk("R5 idle low after frame", sclk_o, 1'b0);
    host_rd(2'd3, 1'b1, d);
    host_wr(2'd0, 8'h03);
    repeat (2) @(negedge clk_i);
    chk("R5 idle high at pol 0", sclk_o, 1'b1);

    // R10 ready stays high in internal mode
    host_wr(2'd1, 8'd0);
    host_wr(2'd0, 8'h23);
    rts_low = 0;
    fork
      host_wr(2'd2, 8'h77);
      repeat (30) @(negedge clk_i) if (!rts_no) rts_low++;
    join
    chk("R10 rts inactive with internal clock", rts_low, 0);
    host_rd(2'd3, 1'b1, d);

    // R9 R10 external clock
    sclk_i = 1'b1;
    host_wr(2'd0, 8'h27);
    repeat (4) @(negedge clk_i);
    chk("R5 clock pin released in external mode", sclk_oe_o, 1'b0);
    chk("R10 rts high with no data", rts_no, 1'b1);
    host_wr(2'd2, 8'h96);
    repeat (4) @(negedge clk_i);
    chk("R10 rts low when armed", rts_no, 1'b0);
    i0 = irq_cnt;
    rts_mid = 1'b0;
    for (int i = 0; i < 8; i++) begin
      repeat (8) @(negedge clk_i);
      sclk_i = 1'b0;
      rxd_i = 8'h5A >> i;
      repeat (8) @(negedge clk_i);
      cap[i] = txd_o;
      if (i == 0) rts_mid = rts_no;
      sclk_i = 1'b1;
    end
    repeat (10) @(negedge clk_i);
    chk("R10 rts high once frame began", rts_mid, 1'b1);
    chk("R9 external tx bits", cap, 8'h96);
    chk("R9 external irq", irq_cnt - i0, 1);
    host_rd(2'd3, 1'b1, d);
    chk("R9 external rx data", d, 8'h5A);
    chk("R10 rts high after frame", rts_no, 1'b1);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule